// File: doc/BRIEF.md
# Timer and Event Counter Unit

This block holds one 8-bit up-counter that a controller core can run from either of two sources. In timer mode the counter advances once for every 32 instruction-cycle strobes, which gives a fixed time base. In event mode it counts completed high-to-low transitions of an external test pin. That pin is sampled only when the cycle strobe is present. A halt command stops both sources. Software can load the count in parallel and read it at any time. A wrap past the top value sets a sticky overflow flag, so long intervals can be accumulated in software.

Whatever the mode, the sampled level of the test pin is always presented on a separate output so that branch logic can test it. Starting either source never clears the count. The start commands only choose where the increments come from.

Top module: `tmr_evt_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the count reads 0x00, the overflow flag reads 0, the test-level output reads 0 and no source is selected.
- R2: A start-timer command leaves the count register unchanged.
- R3: In timer mode the count advances by one on every 32nd cycle strobe. The first advance comes on the 32nd strobe after the start-timer command, because any accepted start-timer command restarts the 5-bit prescaler at zero. Strobes that arrive in the same clock as the command are not counted.
- R4: In event mode the pin is sampled only in clocks that carry the cycle strobe. A low sample advances the count by exactly one only when the previous sample taken in event mode was high. A high sample never advances the count.
- R5: Every accepted start-counter command forgets any earlier high sample. A low sample taken straight after entering event mode therefore never advances the count.
- R6: The clock after a halt command, the count stops changing except through a parallel load.
- R7: The test-level output takes the pin value on every clock that carries the strobe and holds it otherwise, in every mode.
- R8: When an increment takes the count from 0xFF to 0x00, the overflow flag is set in the same clock. The flag stays set until the clear input is applied. A clear applied in the same clock as a wrap loses to the set.
- R9: A parallel load sets the count to the load value on the next clock. The load wins over an increment in the same clock and never changes the overflow flag.
- R10: A start-counter command issued while the timer runs switches the source without changing the count.
- R11: When commands arrive together, halt wins over start-counter and start-counter wins over start-timer.
- R12: Apart from a load, the count changes by at most +1 per clock, and only in a clock that carries the cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cyc_stb_i | input | 1 | One-clock strobe per instruction cycle |
| cmd_tmr_i | input | 1 | Start-timer command |
| cmd_evt_i | input | 1 | Start-counter (event mode) command |
| cmd_halt_i | input | 1 | Stop both sources |
| ld_en_i | input | 1 | Parallel load enable |
| ld_val_i | input | 8 | Parallel load value |
| cnt_o | output | 8 | Current count |
| pin_i | input | 1 | Raw test pin |
| pin_lvl_o | output | 1 | Sampled test-pin level for branch logic |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_clr_i | input | 1 | Clears the overflow flag |

## Verification
The hardest case to reach is a wrap into overflow that coincides with a clear, a load or a command. A 32-strobe prescaler period meets a 256-value count only rarely when the inputs are random. The directed part of the stimulus loads the count near 0xFF before it runs the timer or event sequences, so wraps arrive within a few dozen strobes. The random part then crosses commands, loads and clears with strobes and pin toggles around those wraps. A further case needs a high sample left over from before a new start-counter command. The stimulus sets this up by driving the pin high in timer mode and low just after the switch.

// File: rtl/tec_pkg.sv
package tec_pkg;
  localparam int unsigned TEC_CNT_W = 8;
  localparam int unsigned TEC_PSC_W = 5;

  typedef enum logic [1:0] {
    TEC_IDLE = 2'd0,
    TEC_TMR  = 2'd1,
    TEC_EVT  = 2'd2
  } tec_mode_e;
endpackage

// File: rtl/tec_rst_sync.sv
module tec_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/tec_mode_ctl.sv
module tec_mode_ctl
  import tec_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cmd_tmr_i,
  input  logic      cmd_evt_i,
  input  logic      cmd_halt_i,
  output tec_mode_e mode_o,
  output logic      enter_tmr_o,
  output logic      enter_evt_o
);
  tec_mode_e mode_q;
  tec_mode_e mode_d;

  // halt > event > timer
  always_comb begin
    mode_d      = mode_q;
    enter_tmr_o = 1'b0;
    enter_evt_o = 1'b0;
    if (cmd_halt_i) begin
      mode_d = TEC_IDLE;
    end else if (cmd_evt_i) begin
      mode_d      = TEC_EVT;
      enter_evt_o = 1'b1;
    end else if (cmd_tmr_i) begin
      mode_d      = TEC_TMR;
      enter_tmr_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= TEC_IDLE;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/tec_prescaler.sv
module tec_prescaler #(
  parameter int unsigned PSC_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic step_i,
  output logic tick_o
);
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] psc_d;

  always_comb begin
    psc_d = psc_q;
    if (restart_i)   psc_d = '0;
    else if (step_i) psc_d = psc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psc_q <= '0;
    else         psc_q <= psc_d;
  end

  assign tick_o = step_i && (psc_q == {PSC_W{1'b1}});
endmodule

// File: rtl/tec_edge_det.sv
module tec_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic pin_i,
  input  logic active_i,
  input  logic forget_i,
  output logic tick_o,
  output logic lvl_o
);
  logic hi_seen_q, hi_seen_d;
  logic lvl_q, lvl_d;

  always_comb begin
    hi_seen_d = hi_seen_q;
    if (forget_i)                hi_seen_d = 1'b0;
    else if (active_i && stb_i)  hi_seen_d = pin_i;
    lvl_d = stb_i ? pin_i : lvl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_seen_q <= 1'b0;
      lvl_q     <= 1'b0;
    end else begin
      hi_seen_q <= hi_seen_d;
      lvl_q     <= lvl_d;
    end
  end

  assign tick_o = active_i && stb_i && hi_seen_q && !pin_i;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/tec_counter.sv
module tec_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             inc_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             wrap;

  always_comb begin
    wrap  = !ld_i && inc_i && (cnt_q == {CNT_W{1'b1}});
    cnt_d = cnt_q;
    if (ld_i)       cnt_d = ld_val_i;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
    ovf_d = wrap || (ovf_q && !ovf_clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/tmr_evt_unit.sv
module tmr_evt_unit
  import tec_pkg::*;
#(
  parameter int unsigned CNT_W    = TEC_CNT_W,
  parameter int unsigned PSC_W    = TEC_PSC_W,
  parameter int unsigned RST_SYNC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_stb_i,
  input  logic             cmd_tmr_i,
  input  logic             cmd_evt_i,
  input  logic             cmd_halt_i,
  input  logic             ld_en_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o,
  input  logic             pin_i,
  output logic             pin_lvl_o,
  output logic             ovf_o,
  input  logic             ovf_clr_i
);
  logic      rst_sync_n;
  tec_mode_e mode_q;
  logic      enter_tmr, enter_evt;
  logic      tmr_step, tmr_tick, evt_tick, inc;

  tec_rst_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_sync_n)
  );

  tec_mode_ctl u_mode (
    .clk_i(clk_i), .rst_ni(rst_sync_n),
    .cmd_tmr_i(cmd_tmr_i), .cmd_evt_i(cmd_evt_i), .cmd_halt_i(cmd_halt_i),
    .mode_o(mode_q), .enter_tmr_o(enter_tmr), .enter_evt_o(enter_evt)
  );

  assign tmr_step = cyc_stb_i && (mode_q == TEC_TMR);

  tec_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i(clk_i), .rst_ni(rst_sync_n),
    .restart_i(enter_tmr), .step_i(tmr_step), .tick_o(tmr_tick)
  );

  tec_edge_det u_edge (
    .clk_i(clk_i), .rst_ni(rst_sync_n),
    .stb_i(cyc_stb_i), .pin_i(pin_i),
    .active_i(mode_q == TEC_EVT), .forget_i(enter_evt),
    .tick_o(evt_tick), .lvl_o(pin_lvl_o)
  );

  // source select on the current mode
  always_comb begin
    unique case (mode_q)
      TEC_TMR: inc = tmr_tick;
      TEC_EVT: inc = evt_tick;
      default: inc = 1'b0;
    endcase
  end

  tec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_sync_n),
    .ld_i(ld_en_i), .ld_val_i(ld_val_i), .inc_i(inc),
    .ovf_clr_i(ovf_clr_i), .cnt_o(cnt_o), .ovf_o(ovf_o)
  );
endmodule

// File: rtl/tec_chk.sv
module tec_chk
  import tec_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_n,
  input tec_mode_e        mode,
  input logic             cyc_stb_i,
  input logic             cmd_tmr_i,
  input logic             cmd_halt_i,
  input logic             ld_en_i,
  input logic [CNT_W-1:0] ld_val_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             pin_i,
  input logic             pin_lvl_o,
  input logic             ovf_o,
  input logic             ovf_clr_i
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  p_tmr_start_keeps_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cmd_tmr_i && mode == TEC_IDLE && !ld_en_i) |=> $stable(cnt_o));

  p_evt_high_no_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode == TEC_EVT && cyc_stb_i && pin_i && !ld_en_i) |=> $stable(cnt_o));

  p_halt_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    cmd_halt_i |=> (mode == TEC_IDLE));

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode == TEC_IDLE && !ld_en_i) |=> $stable(cnt_o));

  p_lvl_take_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    cyc_stb_i |=> (pin_lvl_o == $past(pin_i)));

  p_lvl_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !cyc_stb_i |=> $stable(pin_lvl_o));

  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  p_wrap_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cnt_o == TOP && !ld_en_i && cyc_stb_i) |=> (cnt_o == TOP || ovf_o));

  p_ovf_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(ovf_o) |-> ($past(cnt_o) == TOP && cnt_o == '0 && !$past(ld_en_i)));

  p_load_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    ld_en_i |=> (cnt_o == $past(ld_val_i)));

  p_no_stb_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!ld_en_i && !cyc_stb_i) |=> $stable(cnt_o));

  p_step_one_r12: assert property (@(posedge clk_i) disable iff (!rst_n)
    !ld_en_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));
endmodule

bind tmr_evt_unit tec_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_n(rst_sync_n), .mode(mode_q),
  .cyc_stb_i(cyc_stb_i), .cmd_tmr_i(cmd_tmr_i), .cmd_halt_i(cmd_halt_i),
  .ld_en_i(ld_en_i), .ld_val_i(ld_val_i), .cnt_o(cnt_o),
  .pin_i(pin_i), .pin_lvl_o(pin_lvl_o), .ovf_o(ovf_o), .ovf_clr_i(ovf_clr_i)
);

// File: tb/tmr_evt_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_evt_unit_tb_top;
  localparam int unsigned W = 8;

  logic clk = 1'b0;
  logic rst_ni;
  logic stb, c_tmr, c_evt, c_halt, ld, clr, pin;
  logic [W-1:0] ldv;
  logic [W-1:0] cnt;
  logic lvl, ovf;

  int checks = 0;
  int fails  = 0;

  // bench-side reference state: 0 idle, 1 timer, 2 event
  int       m_mode;
  bit [4:0] m_psc;
  bit       m_hs, m_ovf, m_lvl;
  bit [7:0] m_cnt;

  always #4 clk = ~clk;

  tmr_evt_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_stb_i(stb),
    .cmd_tmr_i(c_tmr), .cmd_evt_i(c_evt), .cmd_halt_i(c_halt),
    .ld_en_i(ld), .ld_val_i(ldv), .cnt_o(cnt),
    .pin_i(pin), .pin_lvl_o(lvl), .ovf_o(ovf), .ovf_clr_i(clr)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic bit [7:0] nxt_cnt(bit [7:0] c, bit l, bit [7:0] v, bit inc);
    return l ? v : (inc ? c + 8'd1 : c);
  endfunction

  task automatic model(input bit s, p, t, e, h, l, input bit [7:0] v, input bit cl);
    bit tt, te, inc, wrap;
    tt   = (m_mode == 1) && s && (m_psc == 5'd31);
    te   = (m_mode == 2) && s && m_hs && !p;
    inc  = tt || te;
    wrap = !l && inc && (m_cnt == 8'hFF);
    if (h)                      ;
    else if (e)                 m_hs = 1'b0;
    else if (m_mode == 2 && s)  m_hs = p;
    if (!h && e) ;
    else if (!h && t)           m_psc = 5'd0;
    else if (m_mode == 1 && s)  m_psc = m_psc + 5'd1;
    if (h && m_mode == 2 && s)  m_hs = p;
    if (!h && !e && t && m_mode == 2 && s) m_hs = p;
    if (!h && e && m_mode == 1 && s) m_psc = m_psc + 5'd1;
    if (h && m_mode == 1 && s)  m_psc = m_psc + 5'd1;
    m_cnt = nxt_cnt(m_cnt, l, v, inc);
    m_ovf = wrap || (m_ovf && !cl);
    if (s) m_lvl = p;
    if (h)      m_mode = 0;
    else if (e) m_mode = 2;
    else if (t) m_mode = 1;
  endtask

  // drive one clock at the negedge, compare after the next negedge
  task automatic step(input string tag, input bit s, p, t, e, h, l,
                      input bit [7:0] v, input bit cl);
    stb = s; pin = p; c_tmr = t; c_evt = e; c_halt = h; ld = l; ldv = v; clr = cl;
    model(s, p, t, e, h, l, v, cl);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " cnt"}, cnt, m_cnt);
    chk({tag, " ovf"}, ovf, m_ovf);
    chk({"R7 ", tag, " lvl"}, lvl, m_lvl);
  endtask

  task automatic idle(input string tag, input bit p);
    step(tag, 0, p, 0, 0, 0, 0, 8'h00, 0);
  endtask

  task automatic strobe(input string tag, input bit p);
    step(tag, 1, p, 0, 0, 0, 0, 8'h00, 0);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 1'b0;
    stb = 0; pin = 0; c_tmr = 0; c_evt = 0; c_halt = 0; ld = 0; ldv = '0; clr = 0;
    m_mode = 0; m_psc = 0; m_hs = 0; m_ovf = 0; m_lvl = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    chk("R1 cnt in reset", cnt, 0);
    chk("R1 ovf in reset", ovf, 0);
    chk("R1 lvl in reset", lvl, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cnt after reset", cnt, 0);
    // R1: no source selected, strobes and pin edges do nothing
    strobe("R1", 1); strobe("R1", 0); strobe("R1", 1);
    chk("R1 idle count", cnt, 0);

    // R9 load, R2 timer start keeps count, R3 first tick on 32nd strobe
    step("R9 load", 0, 0, 0, 0, 0, 1, 8'hF0, 0);
    chk("R9 load value", cnt, 8'hF0);
    step("R2 start timer with strobe", 1, 0, 1, 0, 0, 0, 8'h00, 0);
    chk("R2 count kept", cnt, 8'hF0);
    for (int i = 0; i < 31; i++) strobe("R3", 0);
    chk("R3 no tick after 31 strobes", cnt, 8'hF0);
    idle("R3", 0);
    chk("R3 no tick without strobe", cnt, 8'hF0);
    strobe("R3", 0);
    chk("R3 tick on 32nd strobe", cnt, 8'hF1);

    // R8 wrap and sticky flag
    step("R9 load FF", 0, 0, 0, 0, 0, 1, 8'hFF, 0);
    for (int i = 0; i < 32; i++) strobe("R8", 0);
    chk("R8 wrapped count", cnt, 8'h00);
    chk("R8 overflow set", ovf, 1);
    for (int i = 0; i < 5; i++) idle("R8", 0);
    chk("R8 overflow sticky", ovf, 1);
    step("R8 clear", 0, 0, 0, 0, 0, 0, 8'h00, 1);
    chk("R8 overflow cleared", ovf, 0);
    // R8 set wins over a simultaneous clear
    step("R9 load FF", 0, 0, 1, 0, 0, 1, 8'hFF, 0);
    for (int i = 0; i < 31; i++) strobe("R8", 0);
    step("R8 wrap with clear", 1, 0, 0, 0, 0, 0, 8'h00, 1);
    chk("R8 set beats clear", ovf, 1);
    step("R8 clear", 0, 0, 0, 0, 0, 0, 8'h00, 1);

    // R10 switch timer to event keeps count, R5 stale high forgotten
    step("R9 load 10", 0, 0, 0, 0, 0, 1, 8'h10, 0);
    strobe("R7 high in timer", 1);
    chk("R7 level high", lvl, 1);
    step("R10 start counter", 0, 1, 0, 1, 0, 0, 8'h00, 0);
    chk("R10 count kept", cnt, 8'h10);
    strobe("R5", 0);
    chk("R5 no inc on first low", cnt, 8'h10);
    strobe("R4", 1);
    chk("R4 high does not inc", cnt, 8'h10);
    strobe("R4", 0);
    chk("R4 high-low incs", cnt, 8'h11);
    strobe("R4", 0);
    chk("R4 second low no inc", cnt, 8'h11);
    idle("R4 high without strobe", 1);
    strobe("R4", 0);
    chk("R4 unsampled high ignored", cnt, 8'h11);
    // R5 high then re-issued start-counter then low
    strobe("R5", 1);
    step("R5 restart counter", 0, 1, 0, 1, 0, 0, 8'h00, 0);
    strobe("R5", 0);
    chk("R5 restart forgets high", cnt, 8'h11);
    // R9 load beats event increment
    strobe("R9", 1);
    step("R9 load vs inc", 1, 0, 0, 0, 0, 1, 8'h33, 0);
    chk("R9 load wins", cnt, 8'h33);

    // R6 halt stops event counting
    strobe("R6", 1);
    step("R6 halt", 0, 1, 0, 0, 1, 0, 8'h00, 0);
    strobe("R6", 0); strobe("R6", 1); strobe("R6", 0);
    chk("R6 halted", cnt, 8'h33);
    // R11 all commands -> halt wins
    step("R11 all cmds", 0, 0, 1, 1, 1, 0, 8'h00, 0);
    for (int i = 0; i < 40; i++) strobe("R11", i[0]);
    chk("R11 halt wins", cnt, 8'h33);
    // R11 counter beats timer
    step("R11 evt+tmr", 0, 0, 1, 1, 0, 0, 8'h00, 0);
    strobe("R11", 1); strobe("R11", 0);
    chk("R11 event selected", cnt, 8'h34);

    // R12 constrained random mix
    for (int i = 0; i < 6000; i++) begin
      bit s, p, t, e, h, l, cl;
      bit [7:0] v;
      s  = ($urandom % 3) != 0;
      p  = ($urandom % 4) != 0 ? lvl ^ bit'($urandom % 2) : pin;
      t  = ($urandom % 50) == 0;
      e  = ($urandom % 60) == 0;
      h  = ($urandom % 90) == 0;
      l  = ($urandom % 70) == 0;
      v  = ($urandom % 2) ? 8'hFE : 8'($urandom);
      cl = ($urandom % 40) == 0;
      step("R12 random", s, p, t, e, h, l, v, cl);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule